// File: doc/BRIEF.md
# Dual-Core Hardware Spinlock Bank

This block holds a set of hardware mutual-exclusion flags shared by two processor cores. Each core has its own register port made of an address, a read strobe, a write strobe and a read data bus. Reading the address of a lock is an atomic test-and-set. If the lock was free, the read takes it and returns a word with only the bit for that lock number set. If the lock was already taken, the read returns zero. A write strobe to a lock address frees that lock. The port carries no write data, because the value written has no meaning.

One extra address returns a bitmap of every lock, with 1 meaning held. Conflicts in a single cycle are resolved in fixed hardware. When both cores claim the same free lock, core 0 gets it. A read always reports the state from before that cycle's updates. Software uses the block to guard shared data structures between the cores without any bus-level atomic operations.

Top module: `spinlock_bank`

## Requirements
- R1: After reset every lock is free, both read data buses are zero, and a status read returns zero.
- R2: A read of a held lock (address n, n < NUM_LOCKS) returns zero, and the lock stays held.
- R3: A read of a free lock n returns a word with only bit n set, and the lock is held from the next cycle on.
- R4: A write strobe to lock address n frees lock n from the next cycle on. A write to a lock that is already free leaves every lock unchanged.
- R5: When both cores read the same free lock in one cycle, core 0 receives the one-hot value, core 1 receives zero, and the lock ends up held.
- R6: A read of address NUM_LOCKS returns the bitmap of all locks, with bit n being lock n. The bitmap is taken before the updates of that cycle, and the read changes no lock.
- R7: When one core writes a lock in the same cycle that the other core reads it, the read sees the state before the release, and the lock ends up free.
- R8: When one core claims a free lock in the same cycle that the other core writes it, the claim wins and the lock ends up held.
- R9: Read data appears on the cycle after the read strobe. On a cycle after no read strobe, the read data is zero.
- R10: A read of any address above NUM_LOCKS returns zero, and a write to such an address changes no lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_addr | input | ADDR_W (6) | Core 0 register address |
| c0_rd | input | 1 | Core 0 read strobe (test-and-set or status) |
| c0_wr | input | 1 | Core 0 write strobe (release) |
| c0_rdata | output | DATA_W (32) | Core 0 read data, one cycle after the strobe |
| c1_addr | input | ADDR_W (6) | Core 1 register address |
| c1_rd | input | 1 | Core 1 read strobe |
| c1_wr | input | 1 | Core 1 write strobe |
| c1_rdata | output | DATA_W (32) | Core 1 read data, one cycle after the strobe |

## Verification
The bench builds the block with its defaults: 32 locks on a 32-bit data bus. With these values the status bitmap fills the whole word, and the one-hot results reach both edge bits, 0 and 31. The address field is 6 bits wide, so addresses 33 to 63 are unmapped and get probed, both alone and mixed with real traffic. Random traffic is kept to a few locks so that same-cycle collisions between the cores are frequent. These collisions are claim against claim, claim against release, and release against a held lock.

// File: rtl/spin_pkg.sv
package spin_pkg;
   // Address width that covers every lock plus the status word.
   function automatic int addr_bits(input int n_locks);
      int w;
      w = 1;
      while ((1 << w) < (n_locks + 1)) w++;
      return w;
   endfunction

   // Index width for selecting one lock.
   function automatic int idx_bits(input int n_locks);
      int w;
      w = 1;
      while ((1 << w) < n_locks) w++;
      return w;
   endfunction
endpackage

// File: rtl/spin_port_decode.sv
module spin_port_decode #(
   parameter int NUM_LOCKS = 32,
   parameter int ADDR_W    = 6
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 rd,
   input  logic                 wr,
   output logic [NUM_LOCKS-1:0] rd_hit,
   output logic [NUM_LOCKS-1:0] wr_hit,
   output logic                 rd_stat
);
   // One comparator per lock; addresses above NUM_LOCKS match nothing.
   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
      assign rd_hit[i] = rd && (addr == ADDR_W'(i));
      assign wr_hit[i] = wr && (addr == ADDR_W'(i));
   end
   assign rd_stat = rd && (addr == ADDR_W'(NUM_LOCKS));
endmodule

// File: rtl/spin_claim_arb.sv
module spin_claim_arb #(
   parameter int NUM_LOCKS = 32
) (
   input  logic [NUM_LOCKS-1:0] held,
   input  logic [NUM_LOCKS-1:0] rd0,
   input  logic [NUM_LOCKS-1:0] rd1,
   output logic [NUM_LOCKS-1:0] grant0,
   output logic [NUM_LOCKS-1:0] grant1
);
   // Fixed priority per lock: core 0 beats core 1 on a free lock.
   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_arb
      assign grant0[i] = rd0[i] && !held[i];
      assign grant1[i] = rd1[i] && !held[i] && !rd0[i];
   end
endmodule

// File: rtl/spin_lock_state.sv
module spin_lock_state #(
   parameter int NUM_LOCKS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCKS-1:0] set_v,
   input  logic [NUM_LOCKS-1:0] clr_v,
   output logic [NUM_LOCKS-1:0] q
);
   // A set wins over a clear of the same bit in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_v) | set_v;
   end
endmodule

// File: rtl/spin_read_port.sv
module spin_read_port #(
   parameter int NUM_LOCKS = 32,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCKS-1:0] grant,
   input  logic                 rd_stat,
   input  logic [NUM_LOCKS-1:0] held,
   output logic [DATA_W-1:0]    rdata
);
   logic [DATA_W-1:0] rdata_d;

   // A grant vector is already one-hot, so it is the success value.
   always_comb begin
      if (rd_stat) rdata_d = DATA_W'(held);
      else         rdata_d = DATA_W'(grant);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rdata_d;
   end
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank #(
   parameter int NUM_LOCKS = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = spin_pkg::addr_bits(NUM_LOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] c0_addr,
   input  logic              c0_rd,
   input  logic              c0_wr,
   output logic [DATA_W-1:0] c0_rdata,
   input  logic [ADDR_W-1:0] c1_addr,
   input  logic              c1_rd,
   input  logic              c1_wr,
   output logic [DATA_W-1:0] c1_rdata
);
   localparam int IDX_W = spin_pkg::idx_bits(NUM_LOCKS);

   if (NUM_LOCKS < 1 || NUM_LOCKS > DATA_W) begin : g_bad_count
      $error("spinlock_bank: NUM_LOCKS must be between 1 and DATA_W");
   end
   if (ADDR_W < spin_pkg::addr_bits(NUM_LOCKS)) begin : g_bad_addr
      $error("spinlock_bank: ADDR_W too narrow for the status address");
   end

   logic [NUM_LOCKS-1:0] lock_q;
   logic [NUM_LOCKS-1:0] rd0_hit, wr0_hit, rd1_hit, wr1_hit;
   logic [NUM_LOCKS-1:0] grant0, grant1;
   logic                 stat0, stat1;

   spin_port_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec0 (
      .addr(c0_addr), .rd(c0_rd), .wr(c0_wr),
      .rd_hit(rd0_hit), .wr_hit(wr0_hit), .rd_stat(stat0));

   spin_port_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec1 (
      .addr(c1_addr), .rd(c1_rd), .wr(c1_wr),
      .rd_hit(rd1_hit), .wr_hit(wr1_hit), .rd_stat(stat1));

   spin_claim_arb #(.NUM_LOCKS(NUM_LOCKS)) u_arb (
      .held(lock_q), .rd0(rd0_hit), .rd1(rd1_hit),
      .grant0(grant0), .grant1(grant1));

   spin_lock_state #(.NUM_LOCKS(NUM_LOCKS)) u_state (
      .clk(clk), .rst_n(rst_n),
      .set_v(grant0 | grant1), .clr_v(wr0_hit | wr1_hit), .q(lock_q));

   spin_read_port #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_rp0 (
      .clk(clk), .rst_n(rst_n), .grant(grant0), .rd_stat(stat0),
      .held(lock_q), .rdata(c0_rdata));

   spin_read_port #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_rp1 (
      .clk(clk), .rst_n(rst_n), .grant(grant1), .rd_stat(stat1),
      .held(lock_q), .rdata(c1_rdata));

   // ---------------- assertions ----------------
   logic c0_lock, c1_lock;
   assign c0_lock = c0_addr < ADDR_W'(NUM_LOCKS);
   assign c1_lock = c1_addr < ADDR_W'(NUM_LOCKS);

   // R2: a held lock reads as zero
   a_r2_held_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_rd && c0_lock && lock_q[c0_addr[IDX_W-1:0]]) |=> (c0_rdata == '0));

   // R3: a lock read returns at most one set bit
   a_r3_onehot_result: assert property (@(posedge clk) disable iff (!rst_n)
      (c1_rd && c1_lock) |=> $onehot0(c1_rdata));

   // R5: core 0 wins a same-cycle claim
   a_r5_core0_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_rd && c1_rd && c0_lock && (c0_addr == c1_addr) && !lock_q[c0_addr[IDX_W-1:0]])
      |=> (c1_rdata == '0 && c0_rdata != '0));

   // R8: a claim beats a release of the same lock
   a_r8_claim_beats_release: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_rd && c1_wr && c0_lock && (c0_addr == c1_addr) && !lock_q[c0_addr[IDX_W-1:0]])
      |=> lock_q[$past(c0_addr[IDX_W-1:0])]);

   // R9: no strobe, no data
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !c0_rd |=> (c0_rdata == '0));
endmodule

// File: tb/spinlock_bank_bench.sv
module spinlock_bank_bench;
   localparam int N  = 32;
   localparam int DW = 32;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] c0_addr = '0, c1_addr = '0;
   logic c0_rd = 1'b0, c0_wr = 1'b0, c1_rd = 1'b0, c1_wr = 1'b0;
   logic [DW-1:0] c0_rdata, c1_rdata;

   int compared = 0;
   int mismatched = 0;
   logic [N-1:0] mq = '0;

   always #5 clk = ~clk;

   spinlock_bank u_spinlock_bank (
      .clk(clk), .rst_n(rst_n),
      .c0_addr(c0_addr), .c0_rd(c0_rd), .c0_wr(c0_wr), .c0_rdata(c0_rdata),
      .c1_addr(c1_addr), .c1_rd(c1_rd), .c1_wr(c1_wr), .c1_rdata(c1_rdata));

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd(input bit core1, input logic [AW-1:0] a,
         input bit rd, input logic [AW-1:0] a0, input bit rd0, input logic [N-1:0] q);
      if (!rd) return '0;
      if (a == AW'(N)) return DW'(q);
      if (a > AW'(N)) return '0;
      if (q[a[4:0]]) return '0;
      if (core1 && rd0 && a0 == a) return '0;
      return DW'(1) << a;
   endfunction

   function automatic string tag_of(input bit rd, input logic [AW-1:0] a);
      if (!rd) return "R9";
      if (a == AW'(N)) return "R6";
      if (a > AW'(N)) return "R10";
      return "R3";
   endfunction

   // One cycle: drive at negedge, model, then check one cycle later.
   task automatic cyc(input logic [AW-1:0] a0, input bit r0, input bit w0,
                      input logic [AW-1:0] a1, input bit r1, input bit w1,
                      input string tag);
      logic [DW-1:0] e0, e1;
      logic [N-1:0] setv, clrv;
      string t0, t1;
      e0 = exp_rd(1'b0, a0, r0, a0, r0, mq);
      e1 = exp_rd(1'b1, a1, r1, a0, r0, mq);
      setv = '0; clrv = '0;
      if (r0 && a0 < AW'(N) && !mq[a0[4:0]]) setv[a0[4:0]] = 1'b1;
      if (r1 && a1 < AW'(N) && !mq[a1[4:0]] && !(r0 && a0 == a1)) setv[a1[4:0]] = 1'b1;
      if (w0 && a0 < AW'(N)) clrv[a0[4:0]] = 1'b1;
      if (w1 && a1 < AW'(N)) clrv[a1[4:0]] = 1'b1;
      mq = (mq & ~clrv) | setv;
      c0_addr = a0; c0_rd = r0; c0_wr = w0;
      c1_addr = a1; c1_rd = r1; c1_wr = w1;
      @(posedge clk);
      @(negedge clk);
      c0_rd = 1'b0; c0_wr = 1'b0; c1_rd = 1'b0; c1_wr = 1'b0;
      t0 = (tag != "") ? tag : tag_of(r0, a0);
      t1 = (tag != "") ? tag : tag_of(r1, a1);
      check(t0, "core0 rdata", c0_rdata, e0);
      check(t1, "core1 rdata", c1_rdata, e1);
   endtask

   task automatic status(input string tag);
      cyc(AW'(N), 1'b1, 1'b0, AW'(N), 1'b1, 1'b0, tag);
   endtask

   function automatic logic [AW-1:0] pick();
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 6) return AW'($urandom_range(0, 3));
      if (r < 7) return AW'(31);
      if (r < 8) return AW'(N);
      return AW'($urandom_range(0, 63));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'h5a17));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "core0 rdata after reset", c0_rdata, '0);
      check("R1", "core1 rdata after reset", c1_rdata, '0);
      status("R1");
      // R3: claims at both edge locks
      cyc(AW'(0), 1, 0, AW'(N+1), 0, 0, "R3");
      cyc(AW'(N+1), 0, 0, AW'(31), 1, 0, "R3");
      // R2: held lock reads zero for both cores
      cyc(AW'(31), 1, 0, AW'(0), 1, 0, "R2");
      status("R6");
      // R7: release by core 0 while core 1 reads the same lock
      cyc(AW'(0), 0, 1, AW'(0), 1, 0, "R7");
      status("R7");
      // R4: release of a free lock, then of a held one
      cyc(AW'(5), 0, 1, AW'(N+1), 0, 0, "R4");
      status("R4");
      cyc(AW'(N+1), 0, 0, AW'(31), 0, 1, "R4");
      status("R4");
      // R5: both cores claim lock 7
      cyc(AW'(7), 1, 0, AW'(7), 1, 0, "R5");
      status("R5");
      // R8: core 0 claims lock 9 while core 1 writes it
      cyc(AW'(9), 1, 0, AW'(9), 0, 1, "R8");
      status("R8");
      // R10: unmapped read and write
      cyc(AW'(40), 1, 0, AW'(45), 0, 1, "R10");
      cyc(AW'(63), 0, 1, AW'(33), 1, 0, "R10");
      status("R10");
      // R9: idle cycle
      cyc(AW'(0), 0, 0, AW'(0), 0, 0, "R9");
      // random mixed traffic
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] x0, x1;
         bit r0, w0, r1, w1;
         x0 = pick(); x1 = pick();
         r0 = ($urandom_range(0, 2) != 0); w0 = ($urandom_range(0, 2) == 0);
         r1 = ($urandom_range(0, 2) != 0); w1 = ($urandom_range(0, 2) == 0);
         cyc(x0, r0, w0, x1, r1, w1, "");
      end
      status("R6");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule